// File: doc/BRIEF.md
# Reset-Time Boot Sequencer

This block decides how a processor core leaves reset. While the synchronous reset is held, it samples a two-bit boot-mode strap and an endianness strap. On the first clock after reset is released it freezes those values. The core is then kept stalled while one of three boot paths runs. The rest of the chip keeps operating during this time.

The first path is host boot. It waits until a host raises the host interrupt flag. The second is emulation boot, where the sequencer raises that flag by itself. The third is ROM boot. It reads a fixed-size image from an external ROM through a simple synchronous read port and packs the 8-bit or 16-bit ROM elements into 32-bit words. Those words are written to word addresses 0 upward. A done pulse accompanies the final write.

When the selected path finishes, the stall is removed and a one-cycle start pulse tells the core to begin fetching at address 0. After release, the same flag serves as an interrupt source for the core. It raises one interrupt only when it goes from clear to set. The core clears it to re-arm it.

Top module: `boot_sequencer`

## Requirements
- R1: While `rst_n` is low, from the first clock edge onward, `cpu_stall` is 1. In the same period `rom_en`, `mem_we`, `copy_done`, `cpu_start`, `cpu_int` and `dspint_flag` are all 0.
- R2: `strap_mode` and `strap_le` are sampled only while reset is held. Any change to them after reset is released has no effect on the boot path or on the packing order.
- R3: With `strap_mode` = 00 (host boot), `cpu_stall` stays 1 until `host_int_set` is sampled high. It falls in the following cycle and then stays 0 until the next reset.
- R4: In any mode other than host boot, `host_int_set` does not release the core. It still sets `dspint_flag`.
- R5: `cpu_int` pulses for one cycle, in the cycle after `host_int_set` is sampled, only if the core is already released and `dspint_flag` was 0. A set that happens while the core is stalled, or while the flag is already 1, gives no pulse. `cpu_int_clr` clears the flag only after release.
- R6: With `strap_mode` = 01 (emulation boot), with no host action, `dspint_flag` becomes 1 and `cpu_stall` becomes 0 in the second cycle after reset release.
- R7: With `strap_mode` = 10 or 11 (ROM boot), the block reads ROM elements at addresses 0, 1, 2 and so on, once each. The ROM returns data in the cycle after `rom_en`. The block writes IMG_BYTES/4 words to `mem_addr` 0, 1, 2 and so on in ascending order.
- R8: In 8-bit ROM boot (mode 10), word w is built from bytes 4w+k, k = 0..3, each taken from `rom_data[7:0]`. When `strap_le` = 1, byte k goes to bits [8k+7:8k]. When `strap_le` = 0, byte k goes to bits [31-8k:24-8k].
- R9: In 16-bit ROM boot (mode 11), word w is built from half-words 2w and 2w+1. When `strap_le` = 1, half-word 2w goes to bits [15:0]. When `strap_le` = 0, it goes to bits [31:16].
- R10: `copy_done` is high for exactly one cycle, together with the write to the last word address. `cpu_stall` falls in the next cycle.
- R11: `cpu_start` is high for exactly one cycle: the first cycle in which `cpu_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_mode | input | 2 | Boot-mode strap: 00 host, 01 emulation, 10 ROM 8-bit, 11 ROM 16-bit |
| strap_le | input | 1 | Endianness strap, 1 = little-endian |
| host_int_set | input | 1 | Host or emulator request to set the interrupt flag |
| cpu_int_clr | input | 1 | Core request to clear the interrupt flag |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | $clog2(IMG_BYTES) | ROM element address |
| rom_data | input | 16 | ROM read data, valid one cycle after `rom_en` |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | $clog2(IMG_BYTES/4) | Memory word address |
| mem_wdata | output | 32 | Packed write data |
| copy_done | output | 1 | Pulse on the last image word write |
| cpu_stall | output | 1 | Core held stalled |
| cpu_start | output | 1 | One-cycle release pulse, fetch from address 0 |
| cpu_int | output | 1 | Interrupt pulse to the core |
| dspint_flag | output | 1 | Current state of the host interrupt flag |

## Verification
The bench builds the block with the default IMG_BYTES = 1024. That gives 256 word writes and 1024 or 512 ROM reads. At this size the word address counter reaches its all-ones value on the final write, so the done pulse is checked exactly at the counter's boundary. Both read counts are walked in full. All four combinations of ROM width and endianness run over random ROM content. The straps are flipped right after release, and stray host sets arrive in the middle of a copy.

// File: rtl/boot_pkg.sv
// Package: shared encodings for the boot sequencer.
// Assumes a two-bit boot strap and a single sequencer FSM.
package boot_pkg;
    typedef enum logic [1:0] {
        MODE_HOST  = 2'b00,
        MODE_EMU   = 2'b01,
        MODE_ROM8  = 2'b10,
        MODE_ROM16 = 2'b11
    } boot_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_HOST_WAIT = 3'd1,
        ST_EMU_SET   = 3'd2,
        ST_ROM_COPY  = 3'd3,
        ST_RUN       = 3'd4
    } boot_state_e;
endpackage

// File: rtl/boot_strap_capture.sv
// Module: samples the boot straps while reset is held and freezes them
// once reset is released.
// Assumes the straps are stable for at least one clock edge inside reset.
module boot_strap_capture
    import boot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_mode,
    input  logic       strap_le,
    output boot_mode_e mode_q,
    output logic       le_q
);
    // Track straps during reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= boot_mode_e'(strap_mode);
            le_q   <= strap_le;
        end
    end
endmodule

// File: rtl/boot_word_packer.sv
// Module: merges one ROM element into a partially built 32-bit word.
// Assumes lane counts 0..3 for bytes and 0..1 for half-words; pure logic.
module boot_word_packer (
    input  logic [31:0] acc,
    input  logic [15:0] elem,
    input  logic [1:0]  lane,
    input  logic        wide,
    input  logic        le,
    output logic [31:0] acc_nxt
);
    logic [1:0] pos8;
    logic       pos16;

    // Pick the element slot from lane and byte order, then OR it in.
    always_comb begin
        pos8  = le ? lane : (2'd3 - lane);
        pos16 = le ? lane[0] : ~lane[0];
        if (wide)
            acc_nxt = acc | ({16'b0, elem} << {pos16, 4'b0});
        else
            acc_nxt = acc | ({24'b0, elem[7:0]} << {pos8, 3'b0});
    end
endmodule

// File: rtl/boot_rom_copier.sv
// Module: copies the boot image from ROM into word memory from address 0.
// It issues one ROM read per cycle while go is high and packs 8-bit or
// 16-bit elements into 32-bit words.
// Assumes rom_data is valid one cycle after rom_en and that go stays high
// until done.
module boot_rom_copier #(
    parameter int IMG_BYTES = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic                         wide,
    input  logic                         le,
    output logic                         rom_en,
    output logic [$clog2(IMG_BYTES)-1:0] rom_addr,
    input  logic [15:0]                  rom_data,
    output logic                         mem_we,
    output logic [$clog2(IMG_BYTES/4)-1:0] mem_addr,
    output logic [31:0]                  mem_wdata,
    output logic                         done
);
    localparam int ROM_AW = $clog2(IMG_BYTES);
    localparam int WORDS  = IMG_BYTES / 4;
    localparam int WAW    = $clog2(WORDS);
    localparam int CNT_W  = ROM_AW + 1;

    logic [CNT_W-1:0] issue_cnt;
    logic [CNT_W-1:0] elem_total;
    logic             rd_vld;
    logic [1:0]       lane;
    logic [1:0]       last_lane;
    logic [31:0]      acc;
    logic [31:0]      packed_w;
    logic [WAW-1:0]   wr_cnt;

    assign elem_total = wide ? CNT_W'(IMG_BYTES / 2) : CNT_W'(IMG_BYTES);
    assign last_lane  = wide ? 2'd1 : 2'd3;

    boot_word_packer u_packer (
        .acc     (acc),
        .elem    (rom_data),
        .lane    (lane),
        .wide    (wide),
        .le      (le),
        .acc_nxt (packed_w)
    );

    // Issue sequential ROM reads until every element has been requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_cnt <= '0;
            rom_en    <= 1'b0;
            rom_addr  <= '0;
        end else begin
            rom_en <= 1'b0;
            if (go && (issue_cnt < elem_total)) begin
                rom_en    <= 1'b1;
                rom_addr  <= issue_cnt[ROM_AW-1:0];
                issue_cnt <= issue_cnt + 1'b1;
            end
        end
    end

    // Mark the cycle in which ROM data for the previous read is present.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= rom_en;
    end

    // Accumulate lanes and emit a word write on the final lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            lane      <= '0;
            wr_cnt    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            done   <= 1'b0;
            if (rd_vld) begin
                if (lane == last_lane) begin
                    mem_we    <= 1'b1;
                    mem_wdata <= packed_w;
                    mem_addr  <= wr_cnt;
                    wr_cnt    <= wr_cnt + 1'b1;
                    done      <= (wr_cnt == WAW'(WORDS - 1));
                    acc       <= '0;
                    lane      <= '0;
                end else begin
                    acc  <= packed_w;
                    lane <= lane + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/boot_ctrl.sv
// Module: boot path selection, core stall and release, and the host
// interrupt flag.
// Assumes the mode input is already frozen and copy_done is a single pulse.
module boot_ctrl
    import boot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  boot_mode_e mode,
    input  logic       host_set,
    input  logic       cpu_clr,
    input  logic       copy_done,
    output logic       copy_go,
    output logic       cpu_stall,
    output logic       cpu_start,
    output logic       cpu_int,
    output logic       dspint_flag
);
    boot_state_e state, state_nxt;

    // Next-state choice for the boot path.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE: begin
                case (mode)
                    MODE_HOST: state_nxt = ST_HOST_WAIT;
                    MODE_EMU:  state_nxt = ST_EMU_SET;
                    default:   state_nxt = ST_ROM_COPY;
                endcase
            end
            ST_HOST_WAIT: if (host_set || dspint_flag) state_nxt = ST_RUN;
            ST_EMU_SET:   state_nxt = ST_RUN;
            ST_ROM_COPY:  if (copy_done) state_nxt = ST_RUN;
            default:      state_nxt = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Host flag: set by host or emulation step, cleared by the running core.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dspint_flag <= 1'b0;
        else
            dspint_flag <= host_set | (state == ST_EMU_SET) |
                           (dspint_flag & ~(cpu_clr & (state == ST_RUN)));
    end

    // Interrupt only on a clear-to-set edge seen by a running core.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_int <= 1'b0;
        else        cpu_int <= (state == ST_RUN) & host_set & ~dspint_flag;
    end

    // One-cycle start pulse on entry to the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_start <= 1'b0;
        else        cpu_start <= (state != ST_RUN) && (state_nxt == ST_RUN);
    end

    assign copy_go   = (state == ST_ROM_COPY);
    assign cpu_stall = (state != ST_RUN);
endmodule

// File: rtl/boot_sequencer.sv
// Module: top of the reset-time boot sequencer. It ties strap capture,
// the ROM copy engine and the release controller together.
// Assumes one clock domain, synchronous active-low reset, and a ROM
// with one cycle of read latency.
module boot_sequencer
    import boot_pkg::*;
#(
    parameter int IMG_BYTES = 1024
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     strap_mode,
    input  logic                           strap_le,
    input  logic                           host_int_set,
    input  logic                           cpu_int_clr,
    output logic                           rom_en,
    output logic [$clog2(IMG_BYTES)-1:0]   rom_addr,
    input  logic [15:0]                    rom_data,
    output logic                           mem_we,
    output logic [$clog2(IMG_BYTES/4)-1:0] mem_addr,
    output logic [31:0]                    mem_wdata,
    output logic                           copy_done,
    output logic                           cpu_stall,
    output logic                           cpu_start,
    output logic                           cpu_int,
    output logic                           dspint_flag
);
    boot_mode_e mode_q;
    logic       le_q;
    logic       copy_go;

    boot_strap_capture u_straps (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_mode (strap_mode),
        .strap_le   (strap_le),
        .mode_q     (mode_q),
        .le_q       (le_q)
    );

    boot_rom_copier #(.IMG_BYTES(IMG_BYTES)) u_copier (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (copy_go),
        .wide      (mode_q == MODE_ROM16),
        .le        (le_q),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (copy_done)
    );

    boot_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .host_set    (host_int_set),
        .cpu_clr     (cpu_int_clr),
        .copy_done   (copy_done),
        .copy_go     (copy_go),
        .cpu_stall   (cpu_stall),
        .cpu_start   (cpu_start),
        .cpu_int     (cpu_int),
        .dspint_flag (dspint_flag)
    );
endmodule

// File: rtl/boot_sequencer_chk.sv
// Module: property checker for boot_sequencer, attached with bind.
// Assumes the same parameter value as the bound instance.
module boot_sequencer_chk #(
    parameter int IMG_BYTES = 1024
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           host_int_set,
    input logic                           cpu_int_clr,
    input logic                           mem_we,
    input logic [$clog2(IMG_BYTES/4)-1:0] mem_addr,
    input logic                           copy_done,
    input logic                           cpu_stall,
    input logic                           cpu_start,
    input logic                           cpu_int,
    input logic                           dspint_flag
);
    AST_RESET_STALLS: assert property (@(posedge clk) !rst_n |=> cpu_stall); // R1
    AST_RELEASE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |=> !cpu_stall); // R3
    AST_WRITE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cpu_stall); // R7
    AST_DONE_ON_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |-> (mem_we && (mem_addr == '1))); // R10
    AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |=> !cpu_stall); // R10
    AST_NO_INT_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> (!cpu_stall && dspint_flag)); // R5
    AST_INT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |=> !cpu_int); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dspint_flag && !cpu_int_clr) |=> dspint_flag); // R5
    AST_FLAG_FOLLOWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        host_int_set |=> dspint_flag); // R4
    AST_START_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |-> (!cpu_stall && $past(cpu_stall))); // R11
endmodule

bind boot_sequencer boot_sequencer_chk #(.IMG_BYTES(IMG_BYTES)) u_chk (.*);

// File: tb/boot_sequencer_tb.sv
`timescale 1ns/1ps
module boot_sequencer_tb;
    localparam int IMG_BYTES = 1024;
    localparam int WORDS     = IMG_BYTES / 4;
    localparam int ROM_AW    = $clog2(IMG_BYTES);
    localparam int WAW       = $clog2(WORDS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        strap_mode = 2'b00;
    logic              strap_le = 1'b1;
    logic              host_int_set = 1'b0;
    logic              cpu_int_clr = 1'b0;
    logic              rom_en;
    logic [ROM_AW-1:0] rom_addr;
    logic [15:0]       rom_data;
    logic              mem_we;
    logic [WAW-1:0]    mem_addr;
    logic [31:0]       mem_wdata;
    logic              copy_done, cpu_stall, cpu_start, cpu_int, dspint_flag;

    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    int unsigned rom_seed = 0;

    always #2 clk = ~clk;

    boot_sequencer #(.IMG_BYTES(IMG_BYTES)) u_dut (.*);

    function automatic logic [15:0] rom_val(int unsigned a, int unsigned s);
        logic [31:0] h;
        h = (a * 32'd40503) ^ s ^ (a << 17);
        h = h ^ (h >> 7) ^ (h << 5);
        return h[15:0] ^ h[31:16];
    endfunction

    function automatic logic [31:0] exp_word(int unsigned w, bit wide, bit le, int unsigned s);
        logic [31:0] r = '0;
        if (wide) begin
            for (int k = 0; k < 2; k++)
                if (le) r[16*k +: 16] = rom_val(2*w + k, s);
                else    r[16*(1-k) +: 16] = rom_val(2*w + k, s);
        end else begin
            for (int k = 0; k < 4; k++)
                if (le) r[8*k +: 8] = rom_val(4*w + k, s) & 16'hFF;
                else    r[8*(3-k) +: 8] = rom_val(4*w + k, s) & 16'hFF;
        end
        return r;
    endfunction

    // ROM model: data one cycle after the read strobe.
    always_ff @(posedge clk) if (rom_en) rom_data <= rom_val(rom_addr, rom_seed);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL R7 watchdog: actual=%0d cycles expected=below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic le, input bit check_idle);
        @(negedge clk);
        rst_n = 1'b0; strap_mode = m; strap_le = le;
        host_int_set = 1'b0; cpu_int_clr = 1'b0;
        repeat (3) @(negedge clk);
        if (check_idle) begin
            chk("R1 stall", cpu_stall, 1);
            chk("R1 rom_en", rom_en, 0);
            chk("R1 mem_we", mem_we, 0);
            chk("R1 done", copy_done, 0);
            chk("R1 start", cpu_start, 0);
            chk("R1 int", cpu_int, 0);
            chk("R1 flag", dspint_flag, 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic run_host(input bit check_idle);
        int wait_n = 3 + int'($urandom % 8);
        bit saw_read = 0;
        bit early = 0;
        do_reset(2'b00, 1'($urandom), check_idle);
        strap_mode = 2'b10;            // late strap change must not start a copy
        repeat (wait_n) begin
            @(negedge clk);
            if (rom_en) saw_read = 1;
            if (!cpu_stall) early = 1;
        end
        chk("R2 no ROM reads after late strap change", saw_read, 0);
        chk("R3 held before host set", early, 0);
        host_int_set = 1'b1;
        @(negedge clk); host_int_set = 1'b0;
        chk("R3 released", cpu_stall, 0);
        chk("R11 start pulse", cpu_start, 1);
        chk("R5 no int from stalled set", cpu_int, 0);
        @(negedge clk);
        chk("R11 start single", cpu_start, 0);
        host_int_set = 1'b1;
        @(negedge clk); host_int_set = 1'b0;
        chk("R5 no int while flag set", cpu_int, 0);
        cpu_int_clr = 1'b1;
        @(negedge clk); cpu_int_clr = 1'b0;
        chk("R5 flag cleared", dspint_flag, 0);
        host_int_set = 1'b1;
        @(negedge clk); host_int_set = 1'b0;
        chk("R5 int on fresh set", cpu_int, 1);
        @(negedge clk);
        chk("R5 int one cycle", cpu_int, 0);
        chk("R3 still released", cpu_stall, 0);
    endtask

    task automatic run_emu();
        do_reset(2'b01, 1'($urandom), 0);
        strap_mode = 2'b00;
        @(negedge clk);
        chk("R6 stalled first cycle", cpu_stall, 1);
        @(negedge clk);
        chk("R6 released second cycle", cpu_stall, 0);
        chk("R6 flag set by itself", dspint_flag, 1);
        chk("R5 no int at emulation release", cpu_int, 0);
        host_int_set = 1'b1;
        @(negedge clk); host_int_set = 1'b0;
        chk("R5 no int, flag already set", cpu_int, 0);
    endtask

    task automatic run_rom(input bit wide, input bit le, input bit poke);
        int  rd = 0, wr = 0, guard = 0;
        bit  done_seen = 0, early = 0;
        int  elems = wide ? IMG_BYTES / 2 : IMG_BYTES;
        string dreq = wide ? "R9 half-word packing" : "R8 byte packing";
        rom_seed = $urandom;
        do_reset({1'b1, wide}, le, 0);
        strap_mode = {1'b0, ~wide};    // R2: late changes ignored
        strap_le   = ~le;
        while (!done_seen && guard < 5000) begin
            @(negedge clk);
            guard++;
            host_int_set = 1'b0;
            if (cpu_stall == 1'b0) early = 1;
            if (rom_en) begin
                if (rom_addr != ROM_AW'(rd)) chk("R7 read order", 32'(rom_addr), rd);
                rd++;
            end
            if (mem_we) begin
                chk("R7 write address", 32'(mem_addr), wr);
                chk(dreq, mem_wdata, exp_word(wr, wide, le, rom_seed));
                wr++;
            end
            if (copy_done) begin
                done_seen = 1;
                chk("R10 done with last write", {31'b0, mem_we}, 1);
                chk("R10 done address", 32'(mem_addr), WORDS - 1);
            end
            if (poke && guard == 40) host_int_set = 1'b1;
        end
        chk("R4 no release before copy end", early, 0);
        chk("R7 word count", wr, WORDS);
        chk("R7 read count", rd, elems);
        @(negedge clk);
        chk("R10 released after done", cpu_stall, 0);
        chk("R10 done single", copy_done, 0);
        chk("R11 start pulse", cpu_start, 1);
        if (poke) begin
            chk("R4 flag set by host in ROM mode", dspint_flag, 1);
            chk("R5 no int from stalled set", cpu_int, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_host(1);
        run_emu();
        run_rom(0, 1, 1);
        run_rom(0, 0, 0);
        run_rom(1, 1, 0);
        run_rom(1, 0, 1);
        for (int i = 0; i < 6; i++) begin
            int m = int'($urandom % 4);
            if (m == 0)      run_host(0);
            else if (m == 1) run_emu();
            else             run_rom(m == 3, 1'($urandom), 1'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule